// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block derives a 1 MHz time reference from a faster reference clock whose frequency is not necessarily a whole number of megahertz. A rational ratio register says how many microsecond ticks belong to how many reference clocks. An accumulator turns that ratio into a one-clock tick-enable strobe, which downstream timers use. Each strobe also advances a free-running 32-bit microsecond count. The count wraps modulo 2^32 and raises no flag when it does.

Software reaches the block through a small register port that runs on the reference clock. It writes the ratio, reads the microsecond count, and can freeze the timebase, for example while a debugger halts the system. The ratio can be rewritten at any moment, such as after a power-state resume, and the count is not disturbed.

Top module: `ubase_timebase`

## Requirements
- R1: While reset is held and right after it is released, the count reads 0 and the tick-enable is low. The ratio register returns to 0x000B, which is 1 tick per 12 clocks, so the first 120 clocks after reset give exactly 10 ticks.
- R2: The ratio word has two fields. Bits [15:8] hold P and bits [7:0] hold Q. When P <= Q, the block emits exactly (P+1)*L ticks over any window of (Q+1)*L reference clocks, once the accumulator is below Q+1, so no drift builds up.
- R3: A tick lasts one clock. The count goes up by exactly 1 after each clock in which the tick is high, and it holds in every other clock.
- R4: A read at offset 0x10 returns the current 32-bit microsecond count. Writes to that offset are ignored.
- R5: A write to offset 0x14 loads bits [15:0] of the write data as the ratio word. A read of 0x14 returns 0.
- R6: Bit 0 at offset 0x4C is the freeze control, and reads of 0x4C return it. While it is 1, the tick stays low and both the count and the accumulator phase hold.
- R7: Writing a new ratio leaves the count unchanged.
- R8: When P > Q, the block emits a tick on every unfrozen clock and the accumulator stays at zero.
- R9: Writes to any offset other than 0x14 and 0x4C change nothing. Reads of any offset other than 0x10 and 0x4C return 0.
- R10: The ratio word 0x0000 means one tick per one clock, because both fields are stored as the count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the register port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| us_tick | output | 1 | One-clock microsecond tick-enable |

## Verification
The hardest case to reach is a ratio change that happens while the accumulator still holds a residue larger than the new denominator. After that change the accumulator has to drain before the exact-window rule holds again. The bench writes each new ratio while the timebase is running with an arbitrary phase, lets it settle for longer than any possible drain, and then counts ticks and count increments over a window that is an exact multiple of the denominator. Any error in the phase carried across the change would then show up as a difference of at least one tick.

// File: rtl/ubase_pkg.sv
package ubase_pkg;

  localparam int UB_ADDR_W = 8;
  localparam int UB_DATA_W = 32;
  localparam int UB_FIELD_W = 8;

  localparam logic [UB_ADDR_W-1:0] UB_OFS_COUNT  = 8'h10;
  localparam logic [UB_ADDR_W-1:0] UB_OFS_RATIO  = 8'h14;
  localparam logic [UB_ADDR_W-1:0] UB_OFS_FREEZE = 8'h4C;

  localparam logic [2*UB_FIELD_W-1:0] UB_RATIO_RST = 16'h000B;

  typedef enum logic [1:0] {
    UB_SEL_NONE   = 2'd0,
    UB_SEL_COUNT  = 2'd1,
    UB_SEL_RATIO  = 2'd2,
    UB_SEL_FREEZE = 2'd3
  } ub_sel_e;

  function automatic ub_sel_e ub_decode(input logic [UB_ADDR_W-1:0] a);
    ub_sel_e s;
    if (a == UB_OFS_COUNT) s = UB_SEL_COUNT;
    else if (a == UB_OFS_RATIO) s = UB_SEL_RATIO;
    else if (a == UB_OFS_FREEZE) s = UB_SEL_FREEZE;
    else s = UB_SEL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/ubase_regs.sv
module ubase_regs
  import ubase_pkg::*;
#(
  parameter int ADDR_W  = UB_ADDR_W,
  parameter int DATA_W  = UB_DATA_W,
  parameter int FIELD_W = UB_FIELD_W,
  parameter int CNT_W   = UB_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   cnt_val,
  output logic [FIELD_W-1:0] num_m1,
  output logic [FIELD_W-1:0] den_m1,
  output logic               freeze,
  output logic [DATA_W-1:0]  rdata
);

  localparam int RATIO_W = 2 * FIELD_W;

  logic [RATIO_W-1:0] ratio_q;
  logic               freeze_q;
  ub_sel_e            sel;
  logic               wr_ratio;
  logic               wr_freeze;
  logic               unused_wbits;

  assign sel       = ub_decode(addr);
  assign wr_ratio  = wr_en && (sel == UB_SEL_RATIO);
  assign wr_freeze = wr_en && (sel == UB_SEL_FREEZE);
  assign unused_wbits = ^wdata[DATA_W-1:RATIO_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q  <= UB_RATIO_RST;
      freeze_q <= 1'b0;
    end else begin
      if (wr_ratio)  ratio_q  <= wdata[RATIO_W-1:0];
      if (wr_freeze) freeze_q <= wdata[0];
    end
  end

  assign num_m1 = ratio_q[RATIO_W-1:FIELD_W];
  assign den_m1 = ratio_q[FIELD_W-1:0];
  assign freeze = freeze_q;

  always_comb begin
    rdata = '0;
    unique case (sel)
      UB_SEL_COUNT:  rdata = DATA_W'(cnt_val);
      UB_SEL_FREEZE: rdata = DATA_W'(freeze_q);
      UB_SEL_RATIO:  rdata = '0;
      default:       rdata = '0;
    endcase
  end

  AST_RATIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ratio) |-> ratio_q == $past(wdata[RATIO_W-1:0])); // R5
  AST_RATIO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_ratio) && $past(rst_n)) |-> $stable(ratio_q)); // R9
  AST_FREEZE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_freeze) && $past(rst_n)) |-> $stable(freeze_q)); // R9

endmodule

// File: rtl/ubase_ratio.sv
module ubase_ratio #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               freeze,
  input  logic [FIELD_W-1:0] num_m1,
  input  logic [FIELD_W-1:0] den_m1,
  output logic               tick,
  output logic [FIELD_W-1:0] phase
);

  localparam int SUM_W = FIELD_W + 2;

  logic [FIELD_W-1:0] acc_q;
  logic [FIELD_W-1:0] acc_d;
  logic [SUM_W-1:0]   sum_w;
  logic [SUM_W-1:0]   den_w;
  logic               clamp_w;
  logic               reach_w;

  function automatic logic [SUM_W-1:0] fn_plus1(input logic [FIELD_W-1:0] f);
    return SUM_W'(f) + SUM_W'(1);
  endfunction

  function automatic logic [SUM_W-1:0] fn_sum(input logic [FIELD_W-1:0] a,
                                              input logic [FIELD_W-1:0] n);
    return SUM_W'(a) + fn_plus1(n);
  endfunction

  function automatic logic [FIELD_W-1:0] fn_next(input logic [SUM_W-1:0] s,
                                                 input logic [SUM_W-1:0] d,
                                                 input logic reach,
                                                 input logic clamp);
    logic [SUM_W-1:0] r;
    if (clamp)      r = '0;
    else if (reach) r = s - d;
    else            r = s;
    return r[FIELD_W-1:0];
  endfunction

  assign sum_w   = fn_sum(acc_q, num_m1);
  assign den_w   = fn_plus1(den_m1);
  assign clamp_w = num_m1 > den_m1;
  assign reach_w = sum_w >= den_w;
  assign acc_d   = freeze ? acc_q : fn_next(sum_w, den_w, reach_w, clamp_w);
  assign tick    = !freeze && (clamp_w || reach_w);
  assign phase   = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !tick); // R6
  AST_FROZEN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze) && $past(rst_n)) |-> $stable(acc_q)); // R6
  AST_CLAMP_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clamp_w) && !$past(freeze) && $past(rst_n)) |-> (acc_q == '0)); // R8
  AST_PHASE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clamp_w && !freeze && reach_w) && $past(rst_n)) |-> (acc_q <= $past(acc_q))); // R2

endmodule

// File: rtl/ubase_count.sv
module ubase_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] value
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] fn_inc(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= fn_inc(cnt_q);
  end

  assign value = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && $past(rst_n)) |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(step) && $past(rst_n)) |-> $stable(cnt_q)); // R3

endmodule

// File: rtl/ubase_timebase.sv
module ubase_timebase
  import ubase_pkg::*;
#(
  parameter int ADDR_W  = UB_ADDR_W,
  parameter int DATA_W  = UB_DATA_W,
  parameter int FIELD_W = UB_FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              us_tick
);

  localparam int CNT_W = DATA_W;

  logic [FIELD_W-1:0] num_m1_w;
  logic [FIELD_W-1:0] den_m1_w;
  logic               freeze_w;
  logic               tick_w;
  logic [FIELD_W-1:0] phase_w;
  logic [CNT_W-1:0]   count_w;

  ubase_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FIELD_W(FIELD_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .cnt_val(count_w),
    .num_m1 (num_m1_w),
    .den_m1 (den_m1_w),
    .freeze (freeze_w),
    .rdata  (reg_rdata)
  );

  ubase_ratio #(
    .FIELD_W(FIELD_W)
  ) u_ratio (
    .clk   (clk),
    .rst_n (rst_n),
    .freeze(freeze_w),
    .num_m1(num_m1_w),
    .den_m1(den_m1_w),
    .tick  (tick_w),
    .phase (phase_w)
  );

  ubase_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .step (tick_w),
    .value(count_w)
  );

  assign us_tick = tick_w;

  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n |=> (count_w == '0 && phase_w == '0)); // R1
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase_w <= FIELD_W'((1 << FIELD_W) - 1) && !(tick_w && freeze_w)); // R2
  AST_CFG_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr && !tick_w) && $past(rst_n)) |-> $stable(count_w)); // R7

endmodule

// File: tb/sim_ubase_timebase.sv
`timescale 1ns/1ps
module sim_ubase_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h10;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        us_tick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ubase_timebase u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .us_tick(us_tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h10;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 8'h10;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // counts ticks over n clocks; returns count delta seen at the read port
  task automatic window(input int n, output int ticks, output longint delta);
    logic [31:0] c0;
    ticks = 0;
    reg_addr = 8'h10;
    c0 = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (i == 0) c0 = reg_rdata;
      if (us_tick) ticks++;
    end
    @(posedge clk); #1;
    delta = longint'(reg_rdata - c0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1;
    chk(reg_rdata == 0, "R1 count in reset", reg_rdata, 0);
    chk(us_tick == 1'b0, "R1 tick in reset", us_tick, 0);
    @(negedge clk); rst_n = 1'b1;
    begin
      int t; longint dl;
      window(120, t, dl);
      chk(t == 10, "R1 default ratio ticks", t, 10);
      chk(dl == 10, "R3 default count delta", dl, 10);
    end
    rd(8'h4C, d);
    chk(d == 0, "R6 freeze reset value", d, 0);
  endtask

  task automatic t_ratio(input logic [15:0] cfg, input int lcount, input string req);
    int p, q, t; longint dl;
    p = int'(cfg[15:8]) + 1;
    q = int'(cfg[7:0]) + 1;
    wr(8'h14, {16'h0, cfg});
    idle(300);
    window(q * lcount, t, dl);
    chk(t == p * lcount, req, t, p * lcount);
    chk(dl == longint'(t), "R3 count follows ticks", dl, t);
  endtask

  task automatic t_regs();
    logic [31:0] a, b;
    rd(8'h14, a);
    chk(a == 0, "R5 ratio reads zero", a, 0);
    rd(8'h10, a);
    wr(8'h10, 32'h0);
    rd(8'h10, b);
    chk(b >= a && b != 0, "R4 count write ignored", b, a);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, b);
    chk(b == 0, "R9 undecoded read zero", b, 0);
    rd(8'h4C, b);
    chk(b == 0, "R9 undecoded write left freeze", b, 0);
  endtask

  task automatic t_rewrite();
    logic [31:0] a, b;
    rd(8'h10, a);
    wr(8'h14, 32'h0000_0007);
    rd(8'h10, b);
    chk(b >= a && b - a < 8 && b != 0, "R7 rewrite keeps count", b, a);
  endtask

  task automatic t_freeze();
    logic [31:0] a, b;
    int seen;
    wr(8'h14, 32'h0000_0009);
    idle(40);
    wr(8'h4C, 32'h1);
    rd(8'h4C, a);
    chk(a == 1, "R6 freeze readback", a, 1);
    rd(8'h10, a);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); #1;
      if (us_tick) seen++;
    end
    rd(8'h10, b);
    chk(seen == 0, "R6 no tick while frozen", seen, 0);
    chk(b == a, "R6 count held while frozen", b, a);
    wr(8'h4C, 32'h0);
    begin
      int t; longint dl;
      window(10 * 30, t, dl);
      chk(t == 30, "R6 exact rate after freeze", t, 30);
    end
  endtask

  task automatic t_clamp();
    int t; longint dl;
    wr(8'h14, 32'h0000_0502);
    window(100, t, dl);
    chk(t == 100, "R8 clamp tick every clock", t, 100);
    chk(dl == 100, "R8 clamp count", dl, 100);
  endtask

  initial begin
    fork
      begin
        idle(3);
        t_reset();
        t_ratio(16'h043F, 20, "R2 5 per 64");
        t_ratio(16'h0453, 20, "R2 5 per 84");
        t_ratio(16'h045F, 20, "R2 5 per 96");
        t_ratio(16'h04BF, 10, "R2 5 per 192");
        t_ratio(16'h0019, 30, "R2 1 per 26");
        t_ratio(16'h0307, 40, "R2 4 per 8");
        t_ratio(16'h0000, 200, "R10 1 per 1");
        t_regs();
        t_rewrite();
        t_freeze();
        t_clamp();
        t_ratio(16'h000B, 20, "R2 back to 1 per 12");
        done = 1'b1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule